// File: doc/BRIEF.md
# NVRAM Header Checksum Engine

This block computes a 16-bit checksum over a stretch of a byte-wide non-volatile memory and stores the result back into that memory. A single-cycle start pulse captures three operands: the first byte address of the region, its length in bytes, and the address that receives the result. The engine then walks the region through a synchronous memory port. Each step forms a big-endian 16-bit word from two neighbouring bytes and folds it into a running checksum with a nibble-based update. The window slides by one byte per step, so consecutive words share a byte. If the length is odd, one final step folds in the last byte as the high half of a word whose low half is zero.

When the walk ends, the engine writes the checksum to memory. The high byte goes to the result address and the low byte to the address after it. A one-cycle completion pulse follows. A typical use seals a boot parameter header: the region starts at byte 0x00 and is 0xF8 bytes long, and the result lands at 0xFC/0xFD. The memory port is shared between reads and writes and has a read latency of one cycle.

Top module: `hdr_crc_engine`

## Requirements
- R1: While and after synchronous reset, `busy`, `done`, `mem_rd_en` and `mem_wr_en` are all low.
- R2: The running checksum begins at 0xFFFF on every start. A byte count of zero performs no update and stores 0xFFFF.
- R3: One update with prior checksum c and word v computes p = c XOR v, a = p[3:0] and b = p[7:4] XOR a. The new value is (c >> 8) XOR (a << 3) XOR (a << 8) XOR b XOR (b << 7) XOR (b << 12), kept to 16 bits.
- R4: With N the byte count rounded down to even, the engine performs N updates. Update k (k = 0..N-1) uses the word whose high byte is at base+k and low byte at base+k+1. Addresses wrap modulo the address width.
- R5: For an odd byte count, one further update uses the word {byte at base+N, 0x00}.
- R6: The result is written in two consecutive cycles. The high byte goes to the result address, then the low byte to result address + 1. No other memory location is written.
- R7: `busy` is high from the cycle after an accepted start until the completion pulse. `done` is high for exactly one cycle, the cycle after the low result byte is written.
- R8: A start pulse while `busy` is high has no effect on the job in progress or on memory.
- R9: The memory returns read data one cycle after `mem_rd_en`. The engine never reads and writes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a job |
| base_addr | input | ADDR_W | First byte address of the checksummed region |
| byte_count | input | ADDR_W | Number of bytes in the region |
| dest_addr | input | ADDR_W | Address receiving the high result byte |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Shared memory address |
| mem_wr_data | output | 8 | Byte to be written |
| mem_rd_data | input | 8 | Byte returned one cycle after a read strobe |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach from the ports is a second start that arrives while a job is mid-walk. The bench launches a job, waits a few cycles until reads are in flight, and then pulses start with a different region and a different result address. It then confirms that the stored checksum matches the first job and that the second result address was left untouched. Overlapping windows, the odd trailing byte and address wrap-around are reached through the vector table: it contains odd lengths, a one-byte region, a zero-length region and a region that crosses the top of the address space. Each entry is compared against a model in the bench that is built from the update formula.

// File: rtl/hdr_crc_pkg.sv
package hdr_crc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_HI,
        ST_RD_LO,
        ST_FOLD,
        ST_WR_HI,
        ST_WR_LO,
        ST_FIN
    } eng_state_e;

    localparam logic [15:0] CRC_SEED = 16'hFFFF;

    // Nibble-wise fold of one 16-bit word into the running checksum
    function automatic logic [15:0] crc_fold(input logic [15:0] prev,
                                             input logic [15:0] word);
        logic [15:0] mix;
        logic [15:0] lo_nib;
        logic [15:0] hi_nib;
        mix    = prev ^ word;
        lo_nib = {12'h000, mix[3:0]};
        hi_nib = {12'h000, mix[7:4] ^ mix[3:0]};
        return (prev >> 8) ^ (lo_nib << 3) ^ (lo_nib << 8)
               ^ hi_nib ^ (hi_nib << 7) ^ (hi_nib << 12);
    endfunction

endpackage

// File: rtl/hdr_crc_ctrl.sv
module hdr_crc_ctrl
    import hdr_crc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] byte_count,
    input  logic [ADDR_W-1:0] dest_addr,
    output eng_state_e        state,
    output logic [ADDR_W-1:0] base_q,
    output logic [ADDR_W-1:0] idx_q,
    output logic [ADDR_W-1:0] dest_q,
    output logic              tail_q,
    output logic              load
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

    eng_state_e        state_q;
    logic [ADDR_W-1:0] pairs_q;
    logic              odd_q;
    logic [ADDR_W-1:0] pairs_in;
    logic [ADDR_W-1:0] idx_nx;

    assign pairs_in = {byte_count[ADDR_W-1:1], 1'b0};
    assign idx_nx   = idx_q + STEP;
    assign load     = (state_q == ST_IDLE) && start;
    assign state    = state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            dest_q  <= '0;
            pairs_q <= '0;
            idx_q   <= '0;
            odd_q   <= 1'b0;
            tail_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        base_q  <= base_addr;
                        dest_q  <= dest_addr;
                        pairs_q <= pairs_in;
                        odd_q   <= byte_count[0];
                        idx_q   <= '0;
                        if (pairs_in != '0) begin
                            tail_q  <= 1'b0;
                            state_q <= ST_RD_HI;
                        end else if (byte_count[0]) begin
                            tail_q  <= 1'b1;
                            state_q <= ST_RD_HI;
                        end else begin
                            tail_q  <= 1'b0;
                            state_q <= ST_WR_HI;
                        end
                    end
                end
                ST_RD_HI: state_q <= ST_RD_LO;
                ST_RD_LO: state_q <= ST_FOLD;
                ST_FOLD: begin
                    if (!tail_q && (idx_nx < pairs_q)) begin
                        idx_q   <= idx_nx;
                        state_q <= ST_RD_HI;
                    end else if (!tail_q && odd_q) begin
                        idx_q   <= idx_nx;
                        tail_q  <= 1'b1;
                        state_q <= ST_RD_HI;
                    end else begin
                        state_q <= ST_WR_HI;
                    end
                end
                ST_WR_HI: state_q <= ST_WR_LO;
                ST_WR_LO: state_q <= ST_FIN;
                ST_FIN:   state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // R8: a start while a job runs must not disturb the captured operands
    a_r8_start_ignored_busy: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && start) |=> ($stable(base_q) && $stable(dest_q)));

endmodule

// File: rtl/hdr_crc_accum.sv
module hdr_crc_accum
    import hdr_crc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic        cap_hi,
    input  logic        fold,
    input  logic        tail,
    input  logic [7:0]  rd_data,
    output logic [15:0] crc
);

    logic [15:0] crc_q;
    logic [7:0]  hi_q;
    logic [15:0] word;

    assign word = {hi_q, tail ? 8'h00 : rd_data};
    assign crc  = crc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= CRC_SEED;
            hi_q  <= '0;
        end else if (load) begin
            crc_q <= CRC_SEED;
        end else begin
            if (cap_hi) hi_q  <= rd_data;
            if (fold)   crc_q <= crc_fold(crc_q, word);
        end
    end

endmodule

// File: rtl/hdr_crc_port.sv
module hdr_crc_port
    import hdr_crc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  eng_state_e        state,
    input  logic [ADDR_W-1:0] base_q,
    input  logic [ADDR_W-1:0] idx_q,
    input  logic [ADDR_W-1:0] dest_q,
    input  logic              tail_q,
    input  logic [15:0]       crc,
    output logic              rd_en,
    output logic              wr_en,
    output logic [ADDR_W-1:0] addr,
    output logic [7:0]        wr_data
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

    logic [ADDR_W-1:0] rd_ptr;
    assign rd_ptr = base_q + idx_q;

    always_comb begin
        rd_en   = 1'b0;
        wr_en   = 1'b0;
        addr    = '0;
        wr_data = 8'h00;
        case (state)
            ST_RD_HI: begin
                rd_en = 1'b1;
                addr  = rd_ptr;
            end
            ST_RD_LO: begin
                rd_en = !tail_q;
                addr  = rd_ptr + STEP;
            end
            ST_WR_HI: begin
                wr_en   = 1'b1;
                addr    = dest_q;
                wr_data = crc[15:8];
            end
            ST_WR_LO: begin
                wr_en   = 1'b1;
                addr    = dest_q + STEP;
                wr_data = crc[7:0];
            end
            default: ;
        endcase
    end

    // R9: shared port never carries a read and a write together
    a_r9_no_rd_wr_overlap: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && wr_en));

    // R4: the second read of a step is one byte above the first
    a_r4_low_byte_next: assert property (@(posedge clk) disable iff (rst)
        (rd_en && $past(rd_en) && $past(state) == ST_RD_HI)
        |-> addr == $past(addr) + STEP);

endmodule

// File: rtl/hdr_crc_engine.sv
module hdr_crc_engine
    import hdr_crc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] byte_count,
    input  logic [ADDR_W-1:0] dest_addr,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wr_data,
    input  logic [7:0]        mem_rd_data,
    output logic              busy,
    output logic              done
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

    eng_state_e        state;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] idx_q;
    logic [ADDR_W-1:0] dest_q;
    logic              tail_q;
    logic              load;
    logic [15:0]       crc;

    hdr_crc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .base_addr  (base_addr),
        .byte_count (byte_count),
        .dest_addr  (dest_addr),
        .state      (state),
        .base_q     (base_q),
        .idx_q      (idx_q),
        .dest_q     (dest_q),
        .tail_q     (tail_q),
        .load       (load)
    );

    hdr_crc_accum u_accum (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .cap_hi  (state == ST_RD_LO),
        .fold    (state == ST_FOLD),
        .tail    (tail_q),
        .rd_data (mem_rd_data),
        .crc     (crc)
    );

    hdr_crc_port #(.ADDR_W(ADDR_W)) u_port (
        .clk     (clk),
        .rst     (rst),
        .state   (state),
        .base_q  (base_q),
        .idx_q   (idx_q),
        .dest_q  (dest_q),
        .tail_q  (tail_q),
        .crc     (crc),
        .rd_en   (mem_rd_en),
        .wr_en   (mem_wr_en),
        .addr    (mem_addr),
        .wr_data (mem_wr_data)
    );

    assign busy = (state != ST_IDLE);
    assign done = (state == ST_FIN);

    // R7: completion pulse lasts one cycle and follows a write
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r7_done_after_write: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(mem_wr_en));

    // R6: the high-byte write is followed at once by the low-byte write
    a_r6_write_pair: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && !$past(mem_wr_en))
        |=> (mem_wr_en && mem_addr == $past(mem_addr) + STEP));

endmodule

// File: tb/hdr_crc_engine_test.sv
`timescale 1ns/1ps
module hdr_crc_engine_test;

    localparam int AW = 8;
    localparam int MEM_N = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [AW-1:0] byte_count = '0;
    logic [AW-1:0] dest_addr = '0;
    logic          mem_rd_en;
    logic          mem_wr_en;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wr_data;
    logic [7:0]    mem_rd_data = 8'h00;
    logic          busy;
    logic          done;

    logic [7:0] mem  [MEM_N];
    logic [7:0] snap [MEM_N];

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    hdr_crc_engine #(.ADDR_W(AW)) uut (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .base_addr   (base_addr),
        .byte_count  (byte_count),
        .dest_addr   (dest_addr),
        .mem_rd_en   (mem_rd_en),
        .mem_wr_en   (mem_wr_en),
        .mem_addr    (mem_addr),
        .mem_wr_data (mem_wr_data),
        .mem_rd_data (mem_rd_data),
        .busy        (busy),
        .done        (done)
    );

    // Byte-wide memory model, one-cycle read latency
    always @(posedge clk) begin
        if (mem_wr_en) mem[mem_addr] <= mem_wr_data;
        if (mem_rd_en) mem_rd_data <= mem[mem_addr];
    end

    // {seed, base, count, dest}
    localparam logic [31:0] VEC [7] = '{
        32'h11_00_F8_FC,
        32'h5A_10_07_80,
        32'h33_40_00_90,
        32'hC4_20_01_A0,
        32'h77_F0_20_50,
        32'h9E_30_02_C0,
        32'h2B_60_13_E0
    };

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] upd(input logic [15:0] c, input logic [15:0] v);
        logic [15:0] p, a, b;
        p = c ^ v;
        a = 16'(p[3:0]);
        b = 16'(p[7:4] ^ p[3:0]);
        return 16'((c >> 8) ^ (a << 3) ^ (a << 8) ^ b ^ (b << 7) ^ (b << 12));
    endfunction

    function automatic logic [15:0] model(input logic [7:0] b, input logic [7:0] n);
        logic [15:0] c;
        int pairs;
        c = 16'hFFFF;
        pairs = int'(n) & ~1;
        for (int k = 0; k < pairs; k++)
            c = upd(c, {mem[8'(int'(b) + k)], mem[8'(int'(b) + k + 1)]});
        if (n[0]) c = upd(c, {mem[8'(int'(b) + pairs)], 8'h00});
        return c;
    endfunction

    task automatic fill(input logic [7:0] seed);
        for (int i = 0; i < MEM_N; i++) begin
            mem[i]  = 8'((i * 37 + int'(seed)) ^ (i >> 3));
            snap[i] = mem[i];
        end
    endtask

    task automatic pulse_start(input logic [7:0] b, input logic [7:0] n,
                               input logic [7:0] d);
        base_addr  = b;
        byte_count = n;
        dest_addr  = d;
        start      = 1'b1;
        @(negedge clk);
        start      = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        int cyc = 0;
        ok = 1'b0;
        while (cyc < 5000) begin
            if (done) begin
                ok = 1'b1;
                break;
            end
            @(negedge clk);
            cyc++;
        end
        if (!ok) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected done");
        end
    endtask

    task automatic other_bytes(input string req, input logic [7:0] d);
        int bad = 0;
        for (int i = 0; i < MEM_N; i++)
            if (i != int'(d) && i != int'(8'(d + 8'd1)) && mem[i] !== snap[i]) bad++;
        check(req, 32'(bad), 32'd0);
    endtask

    initial begin
        bit ok;
        logic [15:0] exp;
        fill(8'h00);
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 busy", 32'(busy), 0);
        check("R1 done", 32'(done), 0);
        check("R1 strobes", 32'({mem_rd_en, mem_wr_en}), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle after reset", 32'({busy, done, mem_rd_en, mem_wr_en}), 0);

        // Vector table: R2 R3 R4 R5 R6 R7
        for (int v = 0; v < 7; v++) begin
            fill(VEC[v][31:24]);
            exp = model(VEC[v][23:16], VEC[v][15:8]);
            if (VEC[v][15:8] == 8'h00) check("R2 zero count seed", 32'(exp), 32'hFFFF);
            pulse_start(VEC[v][23:16], VEC[v][15:8], VEC[v][7:0]);
            check("R7 busy after start", 32'(busy), 1);
            wait_done(ok);
            if (ok) begin
                check("R3 R4 R5 R6 high byte", 32'(mem[VEC[v][7:0]]), 32'(exp[15:8]));
                check("R3 R4 R5 R6 low byte", 32'(mem[8'(VEC[v][7:0] + 8'd1)]), 32'(exp[7:0]));
                other_bytes("R6 no stray write", VEC[v][7:0]);
                @(negedge clk);
                check("R7 done one cycle", 32'({done, busy}), 0);
            end
        end

        // R5: single odd byte, directed
        fill(8'h42);
        exp = upd(16'hFFFF, {mem[8'h05], 8'h00});
        pulse_start(8'h05, 8'h01, 8'h70);
        wait_done(ok);
        check("R5 single byte high", 32'(mem[8'h70]), 32'(exp[15:8]));
        check("R5 single byte low", 32'(mem[8'h71]), 32'(exp[7:0]));
        @(negedge clk);

        // R8: start while busy has no effect
        fill(8'hA5);
        exp = model(8'h08, 8'h0A);
        pulse_start(8'h08, 8'h0A, 8'hB0);
        repeat (4) @(negedge clk);
        pulse_start(8'h00, 8'h04, 8'hD0);
        wait_done(ok);
        check("R8 high byte unchanged job", 32'(mem[8'hB0]), 32'(exp[15:8]));
        check("R8 low byte unchanged job", 32'(mem[8'hB1]), 32'(exp[7:0]));
        other_bytes("R8 second dest untouched", 8'hB0);
        @(negedge clk);
        check("R8 back to idle", 32'(busy), 0);

        // R1: reset in mid-job returns to idle with no strobes
        pulse_start(8'h00, 8'h40, 8'hF0);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-job reset", 32'({busy, done, mem_rd_en, mem_wr_en}), 0);
        rst = 1'b0;
        @(negedge clk);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule